// File: doc/BRIEF.md
# Fractional Pulse-Swallowing Clock Enable Generator

This block turns a free-running parent clock into a clock enable that is high for a programmable share of parent cycles. Within every window of 32 parent cycles it lets through `32 - code` cycles and swallows the rest. `code` is a 5-bit value held in a rate register. The passed cycles are spread as evenly as possible: an accumulator adds the multiplier every cycle, and each carry out of its top bit produces one enable pulse.

Software writes the new code into the rate register, which only holds it as a pending value. It then writes the apply bit in a separate command register and polls that bit. The hardware copies the pending code into the active setting at the next 32-cycle frame boundary. It clears the apply bit one cycle after that copy. While the apply bit reads 1 the block is busy, and it ignores writes to either register.

Top module: `frac_clk_swallow`

## Requirements
- R1: After reset the rate code reads 0, the apply bit reads 0, and `clk_en` is high in all 32 cycles of any 32-cycle window.
- R2: The rate register is at word address 1. Its pending code occupies bits 12:8 and reads back the value last accepted. All other bits read 0.
- R3: With a constant active code `c`, every window of 32 consecutive cycles holds exactly `32 - c` enable pulses. Code 0 gives 32 pulses and code 31 gives 1.
- R4: Writing the rate register without issuing an apply leaves the output rate unchanged.
- R5: The command register is at word address 0. Writing it with bit 31 set while idle makes bit 31 read 1 on the next cycle. Writing it with bit 31 clear has no effect.
- R6: The pending code becomes active only on the last cycle of a 32-cycle frame. The apply bit clears on the cycle after that copy, so it reads 1 for at most 34 cycles after it was set.
- R7: A command write made while the apply bit reads 1 is ignored and does not start a second apply.
- R8: A rate register write made while the apply bit reads 1 is ignored, and the pending code keeps its previous value.
- R9: When the multiplier is 16 or less, `clk_en` is never high in two consecutive cycles. When it is 16 or more, `clk_en` is never low in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address (0 command, 1 rate) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| clk_en | output | 1 | Registered clock enable pulses |

## Verification
A register write sampled at one edge is visible on `reg_rdata` at the following negative edge. The bench therefore drives on negative edges and reads half a cycle later. The apply bit is polled once per cycle, and the number of polls must stay within the 34-cycle bound. The active code changes one edge before the apply bit drops, and `clk_en` adds one more register stage. For these reasons pulse counting starts one full cycle after the apply bit reads 0 and covers exactly 32 negative edges. The spacing checks are made over that same window.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    parameter int unsigned FCS_DATA_W    = 32;
    parameter int unsigned FCS_ADDR_W    = 4;
    parameter int unsigned FCS_FRAME_BITS = 5;
    parameter int unsigned FCS_CODE_LSB  = 8;
    parameter int unsigned FCS_APPLY_BIT = 31;
    parameter logic [FCS_ADDR_W-1:0] FCS_CMD_ADDR  = 4'd0;
    parameter logic [FCS_ADDR_W-1:0] FCS_RATE_ADDR = 4'd1;
endpackage

// File: rtl/fcs_regs.sv
module fcs_regs
    import fcs_pkg::*;
#(
    parameter int unsigned DATA_W     = FCS_DATA_W,
    parameter int unsigned ADDR_W     = FCS_ADDR_W,
    parameter int unsigned CODE_W     = FCS_FRAME_BITS,
    parameter int unsigned CODE_LSB   = FCS_CODE_LSB,
    parameter int unsigned APPLY_BIT  = FCS_APPLY_BIT,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = FCS_CMD_ADDR,
    parameter logic [ADDR_W-1:0] RATE_ADDR = FCS_RATE_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              applied,
    output logic [DATA_W-1:0] rdata,
    output logic [CODE_W-1:0] pend,
    output logic              busy
);
    typedef struct packed {
        logic [CODE_W-1:0] pend;
        logic              busy;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (applied) begin
            st_d.busy = 1'b0;
        end
        if (wr && !st_q.busy) begin
            if (addr == RATE_ADDR) begin
                st_d.pend = wdata[CODE_LSB +: CODE_W];
            end
            if (addr == CMD_ADDR && wdata[APPLY_BIT]) begin
                st_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == RATE_ADDR) begin
            rdata[CODE_LSB +: CODE_W] = st_q.pend;
        end else if (addr == CMD_ADDR) begin
            rdata[APPLY_BIT] = st_q.busy;
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    assign pend = st_q.pend;
    assign busy = st_q.busy;
endmodule

// File: rtl/fcs_frame.sv
module fcs_frame
    import fcs_pkg::*;
#(
    parameter int unsigned FRAME_BITS = FCS_FRAME_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  busy,
    input  logic [FRAME_BITS-1:0] pend,
    output logic [FRAME_BITS-1:0] active,
    output logic                  applied
);
    localparam logic [FRAME_BITS-1:0] LAST = '1;

    typedef struct packed {
        logic [FRAME_BITS-1:0] cnt;
        logic [FRAME_BITS-1:0] active;
        logic                  applied;
    } frame_t;

    frame_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.cnt     = st_q.cnt + 1'b1;
        st_d.applied = 1'b0;
        if (st_q.cnt == LAST && busy && !st_q.applied) begin
            st_d.active  = pend;
            st_d.applied = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active  = st_q.active;
    assign applied = st_q.applied;
endmodule

// File: rtl/fcs_accum.sv
module fcs_accum
    import fcs_pkg::*;
#(
    parameter int unsigned FRAME_BITS = FCS_FRAME_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FRAME_BITS-1:0] active,
    output logic                  en
);
    localparam int unsigned SUM_W = FRAME_BITS + 1;
    localparam logic [SUM_W-1:0] FRAME = SUM_W'(1) << FRAME_BITS;

    typedef struct packed {
        logic [FRAME_BITS-1:0] acc;
        logic                  en;
    } acc_t;

    acc_t st_d, st_q;
    logic [SUM_W-1:0] mult;
    logic [SUM_W-1:0] sum;

    always_comb begin
        mult    = FRAME - {1'b0, active};
        sum     = {1'b0, st_q.acc} + mult;
        st_d.acc = sum[FRAME_BITS-1:0];
        st_d.en  = sum[FRAME_BITS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en = st_q.en;
endmodule

// File: rtl/frac_clk_swallow.sv
module frac_clk_swallow
    import fcs_pkg::*;
#(
    parameter int unsigned DATA_W     = FCS_DATA_W,
    parameter int unsigned ADDR_W     = FCS_ADDR_W,
    parameter int unsigned FRAME_BITS = FCS_FRAME_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clk_en
);
    logic [FRAME_BITS-1:0] pend_code;
    logic [FRAME_BITS-1:0] act_code;
    logic                  busy;
    logic                  applied;

    fcs_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CODE_W(FRAME_BITS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .applied(applied), .rdata(reg_rdata),
        .pend(pend_code), .busy(busy)
    );

    fcs_frame #(.FRAME_BITS(FRAME_BITS)) u_frame (
        .clk(clk), .rst_n(rst_n), .busy(busy), .pend(pend_code),
        .active(act_code), .applied(applied)
    );

    fcs_accum #(.FRAME_BITS(FRAME_BITS)) u_accum (
        .clk(clk), .rst_n(rst_n), .active(act_code), .en(clk_en)
    );
endmodule

// File: rtl/frac_clk_swallow_chk.sv
module frac_clk_swallow_chk
    import fcs_pkg::*;
#(
    parameter int unsigned ADDR_W     = FCS_ADDR_W,
    parameter int unsigned FRAME_BITS = FCS_FRAME_BITS
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic                  busy,
    input logic [FRAME_BITS-1:0] pend_code,
    input logic [FRAME_BITS-1:0] act_code,
    input logic                  clk_en
);
    localparam int unsigned LIMIT = (1 << FRAME_BITS) + 2;
    localparam logic [FRAME_BITS-1:0] HALF = FRAME_BITS'(1 << (FRAME_BITS - 1));

    logic [FRAME_BITS+1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end else begin
            busy_cnt <= '0;
        end
    end

    assert_apply_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= (FRAME_BITS+2)'(LIMIT));

    assert_active_only_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(act_code));

    assert_pend_held_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == FCS_RATE_ADDR) |=> $stable(pend_code));

    assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> !busy);

    assert_sparse_spread_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && act_code >= HALF && $stable(act_code)) |=> !clk_en);

    assert_dense_spread_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && act_code <= HALF && $stable(act_code)) |=> clk_en);
endmodule

bind frac_clk_swallow frac_clk_swallow_chk #(
    .ADDR_W(ADDR_W), .FRAME_BITS(FRAME_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .busy(busy), .pend_code(pend_code), .act_code(act_code), .clk_en(clk_en)
);

// File: tb/frac_clk_swallow_test.sv
module frac_clk_swallow_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clk_en;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    localparam int NVEC = 8;
    localparam int VEC [NVEC][2] = '{
        '{0, 32}, '{31, 1}, '{16, 16}, '{1, 31},
        '{20, 12}, '{7, 25}, '{24, 8}, '{10, 22}
    };

    always #2.5 clk = ~clk;

    frac_clk_swallow uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_en(clk_en)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle(output int polls);
        logic [31:0] v;
        polls = 0;
        rd(4'd0, v);
        while (v[31] && polls < 200) begin
            @(negedge clk);
            polls++;
            rd(4'd0, v);
        end
    endtask

    task automatic count_win(output int n, output int dbl_hi, output int dbl_lo);
        logic prev;
        n = 0; dbl_hi = 0; dbl_lo = 0;
        @(negedge clk);
        prev = clk_en;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (clk_en) n++;
            if (clk_en && prev) dbl_hi++;
            if (!clk_en && !prev) dbl_lo++;
            prev = clk_en;
        end
    endtask

    initial begin
        logic [31:0] v;
        int polls, n, hi, lo, exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd(4'd1, v); check("R1 rate code", int'(v), 0);
        rd(4'd0, v); check("R1 apply bit", int'(v), 0);
        count_win(n, hi, lo); check("R1 full rate pulses", n, 32);

        // table walk: R2 R3 R5 R6 R9
        for (int k = 0; k < NVEC; k++) begin
            wr(4'd1, 32'(VEC[k][0]) << 8);
            rd(4'd1, v); check("R2 readback", int'(v), VEC[k][0] << 8);
            wr(4'd0, 32'h8000_0000);
            rd(4'd0, v); check("R5 apply set", int'(v[31]), 1);
            wait_idle(polls);
            check("R6 apply within bound", int'(polls <= 34), 1);
            count_win(n, hi, lo);
            check("R3 pulses per window", n, VEC[k][1]);
            exp = VEC[k][1];
            if (exp <= 16) check("R9 no adjacent pulses", hi, 0);
            if (exp >= 16) check("R9 no adjacent gaps", lo, 0);
        end

        // R4: rate write without apply
        wr(4'd1, 32'(5) << 8);
        count_win(n, hi, lo); check("R4 rate unchanged", n, 22);

        // R5: command write with bit 31 clear
        wr(4'd0, 32'h7fff_ffff);
        rd(4'd0, v); check("R5 zero bit no effect", int'(v), 0);
        count_win(n, hi, lo); check("R5 rate unchanged", n, 22);

        // R7 / R8: writes while busy
        wr(4'd1, 32'(12) << 8);
        wr(4'd0, 32'h8000_0000);
        wr(4'd1, 32'(3) << 8);
        wr(4'd0, 32'h8000_0000);
        wait_idle(polls);
        check("R6 apply within bound busy case", int'(polls <= 32), 1);
        rd(4'd1, v); check("R8 pending kept", int'(v), 12 << 8);
        count_win(n, hi, lo); check("R8 rate from first code", n, 20);
        repeat (40) @(negedge clk);
        rd(4'd0, v); check("R7 no second apply", int'(v), 0);
        rd(4'd2, v); check("R2 unmapped reads zero", int'(v), 0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule